// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between the bus side and the execution side of a 16-bit processor. It keeps a small store of up to six code bytes ahead of execution. Whenever at least two byte slots are free, no fetch is outstanding and the execution side has no operand access waiting, it requests the next sequential code word. The 20-bit fetch address is the code segment shifted left by four bits plus a 16-bit fetch offset.

Returned words are written in as two bytes. A fetch from an odd offset writes one byte only, so every later fetch is word aligned. The consumer sees a valid flag and the oldest byte, and takes one byte per cycle. A control transfer raises the flush input. This empties the store, loads a new fetch offset, and discards the data of a fetch that is still in flight.

Top module: `prefetch_byte_queue`

## Requirements
- R1: After reset `byte_valid` is 0, the fetch offset is `RESET_OFS` (0), and `fetch_req` is high when `opnd_pending` and `jump` are low.
- R2: `fetch_req` is high exactly when no fetch is outstanding, at most `DEPTH-2` bytes are held and `jump` is low, with `opnd_pending` low. Only one fetch is outstanding at a time. A fetch becomes outstanding in the cycle where `fetch_req` and `fetch_gnt` are both high, and ends in the cycle where `fetch_rdy` is high.
- R3: While `opnd_pending` is high, `fetch_req` is low in the same cycle.
- R4: `fetch_addr` equals `code_seg*16 + offset`, modulo 2^20. After an accepted fetch the offset advances modulo 2^16.
- R5: A fetch from an even offset has `fetch_single`=0. Its returned word supplies `fetch_word[7:0]` and then `fetch_word[15:8]`, in that order, and the offset advances by 2.
- R6: A fetch from an odd offset has `fetch_single`=1. Only `fetch_word[15:8]` is stored, and the offset advances by 1.
- R7: Bytes leave in the order they were fetched. `byte_data` is the oldest byte whenever `byte_valid` is high, and `byte_valid` is high exactly when at least one byte is held.
- R8: No more than `DEPTH` (6) bytes are ever held. Once full, six takes empty the store.
- R9: A cycle with `jump` high empties the store, loads `jump_ofs` as the fetch offset and ignores `byte_take` in that cycle. The next request uses the new offset.
- R10: The response to a fetch outstanding at a flush, or arriving in the flush cycle, stores nothing. No new fetch is requested until that response has arrived.
- R11: `byte_take` while `byte_valid` is low has no effect.
- R12: A take and a response in the same cycle both take effect, and the held count changes by the net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_seg | input | 16 | Code segment value |
| jump | input | 1 | Flush on control transfer |
| jump_ofs | input | 16 | New fetch offset loaded on flush |
| opnd_pending | input | 1 | Execution side has an operand access waiting |
| fetch_req | output | 1 | Code fetch request |
| fetch_addr | output | 20 | Physical address of the requested fetch |
| fetch_single | output | 1 | Request is a single byte (odd offset) |
| fetch_gnt | input | 1 | Bus accepts the request this cycle |
| fetch_rdy | input | 1 | Fetch data returned this cycle |
| fetch_word | input | 16 | Returned code word |
| byte_valid | output | 1 | Oldest byte is available |
| byte_data | output | 8 | Oldest byte |
| byte_take | input | 1 | Consumer takes the oldest byte |

## Verification
The hardest case to reach is a flush that lands while a fetch is in flight. The response must then be dropped, either in the flush cycle itself or several cycles later, and meanwhile the store refills from a new offset. The bench's bus model answers grants after zero to two idle cycles. Flushes are issued directly after grants, both in a directed sequence and at random. The bench also uses an odd flush offset at the top of a segment, so that the single-byte path and the offset wrap are covered together.

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue #(
  parameter int DEPTH = 6,
  parameter int OFS_W = 16,
  parameter int ADDR_W = 20,
  parameter logic [OFS_W-1:0] RESET_OFS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  code_seg,
  input  logic              jump,
  input  logic [OFS_W-1:0]  jump_ofs,
  input  logic              opnd_pending,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_single,
  input  logic              fetch_gnt,
  input  logic              fetch_rdy,
  input  logic [15:0]       fetch_word,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  input  logic              byte_take
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int SEG_SHIFT = ADDR_W - OFS_W;

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic [OFS_W-1:0] ofs;
  logic             busy, drop, single_q;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire take_ok = byte_take && (count != '0) && !jump;
  wire rsp_ok  = fetch_rdy && busy && !drop && !jump;
  wire issue   = fetch_req && fetch_gnt;
  wire [CNT_W-1:0] n_in = rsp_ok ? (single_q ? CNT_W'(1) : CNT_W'(2)) : '0;
  wire [7:0] first_b = single_q ? fetch_word[15:8] : fetch_word[7:0];

  assign fetch_req    = !busy && !opnd_pending && !jump && (count <= CNT_W'(DEPTH - 2));
  assign fetch_addr   = (ADDR_W'(code_seg) << SEG_SHIFT) + ADDR_W'(ofs);
  assign fetch_single = ofs[0];
  assign byte_valid   = (count != '0);
  assign byte_data    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rsp_ok) begin
      mem[wr_ptr] <= first_b;
      if (!single_q) mem[step_ptr(wr_ptr)] <= fetch_word[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (jump) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (take_ok) rd_ptr <= step_ptr(rd_ptr);
      if (rsp_ok) wr_ptr <= single_q ? step_ptr(wr_ptr) : step_ptr(step_ptr(wr_ptr));
      count <= count + n_in - CNT_W'(take_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs      <= RESET_OFS;
      busy     <= 1'b0;
      drop     <= 1'b0;
      single_q <= 1'b0;
    end else begin
      if (jump) ofs <= jump_ofs;
      else if (issue) ofs <= ofs + (ofs[0] ? OFS_W'(1) : OFS_W'(2));
      if (issue) begin
        busy     <= 1'b1;
        single_q <= ofs[0];
      end else if (fetch_rdy && busy) begin
        busy <= 1'b0;
      end
      if (fetch_rdy && busy) drop <= 1'b0;
      else if (jump && busy) drop <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R8
  AST_OPND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_pending |-> !fetch_req); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !fetch_req); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> !byte_valid); // R9
  AST_EMPTY_TAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && !byte_valid && !(fetch_rdy && busy)) |=> !byte_valid); // R11
  AST_LOW_BYTE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok && !single_q && !byte_valid) |=> (byte_valid && byte_data == $past(fetch_word[7:0]))); // R5
  AST_ODD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && fetch_single && ofs != '1 && !jump) ##1 $stable(code_seg)
      |-> fetch_addr == $past(fetch_addr) + 1'b1); // R6
  AST_DROP_STORES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_rdy && drop && !byte_take) |=> $stable(byte_valid)); // R10
endmodule

// File: tb/tb_prefetch_byte_queue.sv
module tb_prefetch_byte_queue;
  logic clk = 0, rst_n = 0;
  logic [15:0] code_seg = 0, jump_ofs = 0, fetch_word = 0;
  logic jump = 0, opnd_pending = 0, fetch_gnt = 0, fetch_rdy = 0, byte_take = 0;
  logic fetch_req, fetch_single, byte_valid;
  logic [19:0] fetch_addr;
  logic [7:0] byte_data;

  prefetch_byte_queue dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mq[$];
  logic [15:0] m_ofs = 0;
  bit m_busy = 0, m_drop = 0, m_single = 0;
  logic [19:0] m_addr = 0;
  bit bus_pend = 0;
  int bus_wait = 0;
  string ctx = "R7";

  function automatic logic [7:0] mem_b(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({4'h0, s} << 4) + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit op, input bit take, input bit jmp, input logic [15:0] jofs,
                     input logic [15:0] seg, input bit gnt);
    bit exp_req, rdy, pop_ok;
    @(negedge clk);
    opnd_pending = op; byte_take = take; jump = jmp; jump_ofs = jofs; code_seg = seg; fetch_gnt = gnt;
    rdy = bus_pend && bus_wait == 0;
    fetch_rdy = rdy;
    fetch_word = rdy ? {mem_b({m_addr[19:1], 1'b1}), mem_b({m_addr[19:1], 1'b0})} : 16'h0;
    #1;
    exp_req = !m_busy && !op && !jmp && (mq.size() <= 4);
    chk(fetch_req == exp_req, op ? "R3" : "R2", fetch_req, exp_req);
    if (exp_req) begin
      chk(fetch_addr == phys(seg, m_ofs), "R4", fetch_addr, phys(seg, m_ofs));
      chk(fetch_single == m_ofs[0], m_ofs[0] ? "R6" : "R5", fetch_single, m_ofs[0]);
    end
    chk(byte_valid == (mq.size() != 0), ctx, byte_valid, mq.size() != 0);
    if (mq.size() != 0) chk(byte_data == mq[0], ctx, byte_data, mq[0]);
    @(posedge clk);
    pop_ok = take && mq.size() != 0 && !jmp;
    ctx = "R7";
    if (take && mq.size() == 0 && !jmp) ctx = "R11";
    if (pop_ok && rdy && m_busy && !m_drop) ctx = "R12";
    if (jmp) begin
      mq.delete();
      m_ofs = jofs;
      ctx = "R9";
      if (m_busy && !rdy) m_drop = 1;
      if (rdy) begin m_busy = 0; m_drop = 0; ctx = "R10"; end
    end else begin
      if (pop_ok) void'(mq.pop_front());
      if (rdy && m_busy) begin
        if (m_drop) ctx = "R10";
        else if (m_single) mq.push_back(mem_b(m_addr));
        else begin mq.push_back(mem_b(m_addr)); mq.push_back(mem_b(m_addr + 20'd1)); end
        m_busy = 0; m_drop = 0;
      end
    end
    if (rdy) bus_pend = 0;
    else if (bus_pend && bus_wait > 0) bus_wait--;
    if (exp_req && gnt) begin
      m_busy = 1; m_single = m_ofs[0]; m_addr = phys(seg, m_ofs);
      m_ofs = m_ofs + (m_ofs[0] ? 16'd1 : 16'd2);
      bus_pend = 1; bus_wait = $urandom % 3;
    end
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int got;
    logic [15:0] seg;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(byte_valid == 0, "R1", byte_valid, 0);
    chk(fetch_req == 1, "R1", fetch_req, 1);
    chk(fetch_addr == 20'h0, "R1", fetch_addr, 0);
    seg = 16'h1234;
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, seg, 1);
    got = 0;
    for (int i = 0; i < 8; i++) begin
      #1; if (byte_valid) got++;
      cyc(0, 1, 0, 0, seg, 0);
    end
    chk(got == 6, "R8", got, 6);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, seg, 1);
    cyc(0, 0, 1, 16'h0FFF, seg, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, seg, 1);
      cyc(0, 1, 1, 16'h0FFF, seg, 0);
    end
    seg = 16'hF000;
    cyc(0, 0, 1, 16'hFFFF, seg, 0);
    for (int i = 0; i < 12; i++) cyc(0, i[0], 0, 0, seg, 1);
    seg = 16'hFFFF;
    cyc(0, 0, 1, 16'h0010, seg, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, seg, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, seg, 1);
    for (int i = 0; i < 6000; i++) begin
      bit j = ($urandom % 100) < 4;
      if (j) seg = 16'($urandom);
      cyc(($urandom % 100) < 20, ($urandom % 100) < 50, j, 16'($urandom), seg, ($urandom % 100) < 70);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule